// File: doc/BRIEF.md
# Vehicle Bus Receive Frame Checker

This block sits behind a variable-pulse-width symbol decoder on a single-wire vehicle network. Each cycle it may receive one decoded symbol: start-of-frame, a data byte, end-of-data or noise. It takes that symbol either from the bus-side decoder or from the decoder that watches the node's own transmit line. A control bit picks the source, so software can test the node in loopback.

Symbols from quad-speed traffic carry a flag. When quad-speed reception is disabled, those symbols are dropped as if they never arrived. When it is enabled, they are handled like normal-speed symbols. Inside a frame every byte is presented on a byte output with a one-cycle ready strobe and is folded into a CRC-8. The last byte of the frame is the transmitted check byte. At end-of-data the CRC remainder is compared against a fixed residue.

The outcome is posted to a single-entry status vector. The vector keeps the most important pending condition until software acknowledges it. An interrupt line follows the vector when interrupts are enabled. Frames have no length limit, so long block transfers pass through unchanged.

Top module: `vbus_rx_frame_checker`

## Requirements
- R1: With `loop_sel`=1 only the `lb_*` symbol inputs are used and the `bus_*` inputs have no effect. With `loop_sel`=0 only the `bus_*` inputs are used.
- R2: When `quad_en`=0, a symbol whose quad flag is 1 has no effect. It produces no byte strobe, changes neither the status vector nor the interrupt, and leaves any frame in progress unchanged.
- R3: When `quad_en`=1, quad-flagged symbols are processed exactly like normal-speed symbols.
- R4: Symbol kind encoding is 0=start-of-frame, 1=data, 2=end-of-data, 3=noise. The CRC uses polynomial x^8+x^4+x^3+x^2+1 (0x1D). It is preset to 0xFF at start-of-frame and shifts MSB first over every data byte, including the check byte. At end-of-data a remainder of 0xC4 posts status code 0x04 (frame good).
- R5: At end-of-data any remainder other than 0xC4 posts status code 0x18 (CRC error). An empty frame is included.
- R6: There is no limit on the number of data bytes between start-of-frame and end-of-data.
- R7: `irq` is 1 exactly when `irq_en` is 1 and the status vector is non-zero, as of the previous clock edge.
- R8: A data symbol inside a frame drives `rx_byte` to the byte and pulses `rx_byte_rdy` for one cycle, one clock after the symbol. It also posts status code 0x0C (byte received).
- R9: The status vector holds one code, ranked 0x18 > 0x04 > 0x0C > 0x00. A new event replaces the held code only if it ranks higher. The held code stays until a `stat_ack` pulse clears it to 0x00.
- R10: A start-of-frame inside a frame discards the partial frame and restarts the CRC at 0xFF.
- R11: A noise symbol abandons the frame in progress without posting status. Data and end-of-data symbols outside a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_sel | input | 1 | 1 selects the transmit-line symbol source |
| quad_en | input | 1 | 1 accepts quad-speed symbols |
| irq_en | input | 1 | Interrupt enable |
| bus_sym_vld | input | 1 | Bus-side symbol strobe |
| bus_sym_kind | input | 2 | Bus-side symbol kind |
| bus_sym_quad | input | 1 | Bus-side symbol is quad-speed |
| bus_sym_data | input | 8 | Bus-side byte value |
| lb_sym_vld | input | 1 | Transmit-line symbol strobe |
| lb_sym_kind | input | 2 | Transmit-line symbol kind |
| lb_sym_quad | input | 1 | Transmit-line symbol is quad-speed |
| lb_sym_data | input | 8 | Transmit-line byte value |
| stat_ack | input | 1 | Clears the status vector |
| rx_byte | output | 8 | Last received byte |
| rx_byte_rdy | output | 1 | One-cycle byte strobe |
| stat_code | output | 8 | Status vector |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a correct residue: random bytes almost never leave 0xC4. The stimulus therefore builds most frames by appending the complement of the bench's own CRC of the payload, then flips a random bit in some of them. It also adds a long block frame of several hundred bytes, a restart inside a frame and quad-speed traffic in both enable states. The unselected source is fed random symbols throughout, so any leak through the source select shows up as an unexpected byte or status.

// File: rtl/vbus_rx_pkg.sv
package vbus_rx_pkg;
  typedef enum logic [1:0] {
    SYM_SOF   = 2'd0,
    SYM_DATA  = 2'd1,
    SYM_EOD   = 2'd2,
    SYM_NOISE = 2'd3
  } sym_kind_e;

  localparam int STAT_W = 8;
  typedef logic [STAT_W-1:0] stat_code_t;

  localparam stat_code_t ST_IDLE   = 8'h00;
  localparam stat_code_t ST_BYTE   = 8'h0C;
  localparam stat_code_t ST_FRAME  = 8'h04;
  localparam stat_code_t ST_CRCERR = 8'h18;

  function automatic logic [1:0] stat_rank(input stat_code_t c);
    case (c)
      ST_CRCERR: return 2'd3;
      ST_FRAME:  return 2'd2;
      ST_BYTE:   return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/vbus_rx_srcmux.sv
module vbus_rx_srcmux
  import vbus_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              loop_sel,
  input  logic              quad_en,
  input  logic              bus_vld,
  input  logic [1:0]        bus_kind,
  input  logic              bus_quad,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              lb_vld,
  input  logic [1:0]        lb_kind,
  input  logic              lb_quad,
  input  logic [DATA_W-1:0] lb_data,
  output logic              acc_vld,
  output sym_kind_e         acc_kind,
  output logic [DATA_W-1:0] acc_data
);
  logic       sel_vld;
  logic       sel_quad;
  logic [1:0] sel_kind;

  always_comb begin
    sel_vld  = loop_sel ? lb_vld  : bus_vld;
    sel_quad = loop_sel ? lb_quad : bus_quad;
    sel_kind = loop_sel ? lb_kind : bus_kind;
    acc_data = loop_sel ? lb_data : bus_data;
    acc_kind = sym_kind_e'(sel_kind);
    // quad-speed symbols vanish unless quad reception is on
    acc_vld  = sel_vld && (quad_en || !sel_quad);
  end
endmodule

// File: rtl/vbus_rx_crc.sv
module vbus_rx_crc #(
  parameter int          W      = 8,
  parameter int          DATA_W = 8,
  parameter logic [W-1:0] POLY  = 8'h1D,
  parameter logic [W-1:0] SEED  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [DATA_W-1:0] data,
  output logic [W-1:0]      crc_q
);
  function automatic logic [W-1:0] crc_advance(input logic [W-1:0] c,
                                               input logic [DATA_W-1:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= SEED;
    else if (init) crc_q <= SEED;
    else if (step) crc_q <= crc_advance(crc_q, data);
  end

  // R4 / R10: every frame start leaves the register at the preset
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc_q == SEED);
endmodule

// File: rtl/vbus_rx_status.sv
module vbus_rx_status
  import vbus_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_vld,
  input  stat_code_t evt_code,
  input  logic       ack,
  input  logic       irq_en,
  output stat_code_t stat_code,
  output logic       irq
);
  stat_code_t nxt;

  always_comb begin
    nxt = ack ? ST_IDLE : stat_code;
    if (evt_vld && (stat_rank(evt_code) > stat_rank(nxt))) nxt = evt_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_code <= ST_IDLE;
      irq       <= 1'b0;
    end else begin
      stat_code <= nxt;
      irq       <= irq_en && (nxt != ST_IDLE);
    end
  end

  // R9: a CRC error stays posted until acknowledged
  crcerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == ST_CRCERR && !ack) |=> stat_code == ST_CRCERR);

  // R9: acknowledge without a new event empties the vector
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt_vld) |=> stat_code == ST_IDLE);

  // R7: no request without something pending
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_code != ST_IDLE);
endmodule

// File: rtl/vbus_rx_frame_checker.sv
module vbus_rx_frame_checker
  import vbus_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [CRC_W-1:0] CRC_SEED = 8'hFF,
  parameter logic [CRC_W-1:0] CRC_GOOD = 8'hC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_sel,
  input  logic              quad_en,
  input  logic              irq_en,
  input  logic              bus_sym_vld,
  input  logic [1:0]        bus_sym_kind,
  input  logic              bus_sym_quad,
  input  logic [DATA_W-1:0] bus_sym_data,
  input  logic              lb_sym_vld,
  input  logic [1:0]        lb_sym_kind,
  input  logic              lb_sym_quad,
  input  logic [DATA_W-1:0] lb_sym_data,
  input  logic              stat_ack,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_byte_rdy,
  output logic [7:0]        stat_code,
  output logic              irq
);
  logic              acc_vld;
  sym_kind_e         acc_kind;
  logic [DATA_W-1:0] acc_data;
  logic              in_frame;
  logic [CRC_W-1:0]  crc_q;

  // named internal events
  logic       frame_start, byte_take, frame_end, frame_drop, crc_ok, evt_vld;
  stat_code_t evt_code;
  stat_code_t stat_q;

  vbus_rx_srcmux #(.DATA_W(DATA_W)) u_mux (
    .loop_sel(loop_sel), .quad_en(quad_en),
    .bus_vld(bus_sym_vld), .bus_kind(bus_sym_kind),
    .bus_quad(bus_sym_quad), .bus_data(bus_sym_data),
    .lb_vld(lb_sym_vld), .lb_kind(lb_sym_kind),
    .lb_quad(lb_sym_quad), .lb_data(lb_sym_data),
    .acc_vld(acc_vld), .acc_kind(acc_kind), .acc_data(acc_data)
  );

  assign frame_start = acc_vld && (acc_kind == SYM_SOF);
  assign byte_take   = acc_vld && (acc_kind == SYM_DATA) && in_frame;
  assign frame_end   = acc_vld && (acc_kind == SYM_EOD) && in_frame;
  assign frame_drop  = acc_vld && (acc_kind == SYM_NOISE);
  assign crc_ok      = (crc_q == CRC_GOOD);
  assign evt_vld     = byte_take || frame_end;
  assign evt_code    = frame_end ? (crc_ok ? ST_FRAME : ST_CRCERR) : ST_BYTE;

  vbus_rx_crc #(.W(CRC_W), .DATA_W(DATA_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(frame_start), .step(byte_take),
    .data(acc_data), .crc_q(crc_q)
  );

  vbus_rx_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_code(evt_code),
    .ack(stat_ack), .irq_en(irq_en), .stat_code(stat_q), .irq(irq)
  );
  assign stat_code = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame    <= 1'b0;
      rx_byte     <= '0;
      rx_byte_rdy <= 1'b0;
    end else begin
      rx_byte_rdy <= byte_take;
      if (byte_take) rx_byte <= acc_data;
      if (frame_start)                  in_frame <= 1'b1;
      else if (frame_end || frame_drop) in_frame <= 1'b0;
    end
  end

  // R8: strobe only follows a byte taken inside a frame
  byte_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_rdy |-> $past(byte_take));

  // R11: noise always leaves the frame
  noise_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> !in_frame);

  // R4: a good residue always posts something
  good_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && crc_ok) |=> stat_code != ST_IDLE);

  // R5: a bad residue always posts the error code
  bad_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !crc_ok) |=> stat_code == ST_CRCERR);
endmodule

// File: tb/vbus_rx_frame_checker_test.sv
module vbus_rx_frame_checker_test;
  localparam time CYC = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loop_sel = 0, quad_en = 0, irq_en = 0, stat_ack = 0;
  logic bus_vld = 0, bus_quad = 0, lb_vld = 0, lb_quad = 0;
  logic [1:0] bus_kind = 0, lb_kind = 0;
  logic [7:0] bus_data = 0, lb_data = 0;
  logic [7:0] rx_byte, stat_code;
  logic rx_byte_rdy, irq;

  int vectors = 0, errors = 0;
  bit m_in = 0;
  logic [7:0] m_crc = 8'hFF, m_stat = 8'h00;

  always #(CYC/2) clk = ~clk;

  vbus_rx_frame_checker uut (
    .clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .quad_en(quad_en), .irq_en(irq_en),
    .bus_sym_vld(bus_vld), .bus_sym_kind(bus_kind), .bus_sym_quad(bus_quad), .bus_sym_data(bus_data),
    .lb_sym_vld(lb_vld), .lb_sym_kind(lb_kind), .lb_sym_quad(lb_quad), .lb_sym_data(lb_data),
    .stat_ack(stat_ack), .rx_byte(rx_byte), .rx_byte_rdy(rx_byte_rdy),
    .stat_code(stat_code), .irq(irq)
  );

  // byte-wise CRC form: xor the byte in, then eight shifts
  function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    return r;
  endfunction

  function automatic int rank(input logic [7:0] c);
    if (c == 8'h18) return 3;
    if (c == 8'h04) return 2;
    if (c == 8'h0C) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic post(input logic [7:0] c);
    if (rank(c) > rank(m_stat)) m_stat = c;
  endtask

  // one symbol on the chosen source; the other source carries random junk
  task automatic send(input string req, input bit q, input logic [1:0] k, input logic [7:0] d);
    bit acc, exp_rdy;
    @(negedge clk);
    if (loop_sel) begin
      lb_vld = 1; lb_kind = k; lb_quad = q; lb_data = d;
      bus_vld = 1'($urandom); bus_kind = 2'($urandom); bus_quad = 1'($urandom); bus_data = 8'($urandom);
    end else begin
      bus_vld = 1; bus_kind = k; bus_quad = q; bus_data = d;
      lb_vld = 1'($urandom); lb_kind = 2'($urandom); lb_quad = 1'($urandom); lb_data = 8'($urandom);
    end
    acc = !(q && !quad_en);
    exp_rdy = 0;
    if (acc) begin
      case (k)
        2'd0: begin m_in = 1; m_crc = 8'hFF; end
        2'd1: if (m_in) begin m_crc = crc_byte(m_crc, d); exp_rdy = 1; post(8'h0C); end
        2'd2: if (m_in) begin m_in = 0; post(m_crc == 8'hC4 ? 8'h04 : 8'h18); end
        default: m_in = 0;
      endcase
    end
    @(negedge clk);
    bus_vld = 0; lb_vld = 0;
    check({req, " byte strobe"}, rx_byte_rdy, exp_rdy);
    if (exp_rdy) check({req, " byte value"}, rx_byte, d);
    check({req, " status"}, stat_code, m_stat);
    check({req, " irq"}, irq, irq_en && (m_stat != 0));
  endtask

  task automatic ack(input string req);
    @(negedge clk); stat_ack = 1;
    @(negedge clk); stat_ack = 0; m_stat = 0;
    check({req, " ack clears status"}, stat_code, 8'h00);
    check({req, " ack clears irq"}, irq, 1'b0);
  endtask

  // frame of n payload bytes; good=1 appends the correct check byte
  task automatic frame(input string req, input bit q, input int n, input bit good, input bit flip);
    logic [7:0] c = 8'hFF, b;
    send(req, q, 2'd0, 8'h00);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      c = crc_byte(c, b);
      if (flip && i == 0) b ^= 8'h01;
      send(req, q, 2'd1, b);
    end
    if (good) send(req, q, 2'd1, ~c);
    send(req, q, 2'd2, 8'h00);
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1850_0C4));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset strobe", rx_byte_rdy, 1'b0);
    check("R9 reset status", stat_code, 8'h00);
    check("R7 reset irq", irq, 1'b0);

    // R5: empty frame leaves 0xFF
    send("R5 empty", 0, 2'd0, 0);
    send("R5 empty", 0, 2'd2, 0);
    check("R5 empty frame code", stat_code, 8'h18);
    ack("R9");

    // R4 good frame from bus source, R1 loopback good frame
    frame("R4 good", 0, 4, 1, 0);
    check("R4 good frame code", stat_code, 8'h04);
    ack("R9");
    loop_sel = 1;
    frame("R1 loopback", 0, 3, 1, 0);
    check("R1 loopback frame code", stat_code, 8'h04);
    ack("R9");
    loop_sel = 0;

    // R6 long block frame
    frame("R6 block", 0, 300, 1, 0);
    check("R6 block frame code", stat_code, 8'h04);
    ack("R9");

    // R10 restart mid-frame: garbage then a clean frame
    send("R10 partial", 0, 2'd0, 0);
    send("R10 partial", 0, 2'd1, 8'h5A);
    ack("R10");
    frame("R10 restart", 0, 2, 1, 0);
    check("R10 restarted frame good", stat_code, 8'h04);
    ack("R9");

    // R11 noise drops frame; stray EOD/data ignored
    send("R11 noise", 0, 2'd0, 0);
    send("R11 noise", 0, 2'd3, 0);
    send("R11 stray eod", 0, 2'd2, 0);
    send("R11 stray data", 0, 2'd1, 8'h33);
    check("R11 nothing posted", stat_code, 8'h00);

    // R2 quad ignored, even mid-frame; R3 quad accepted
    quad_en = 0;
    send("R2 open", 0, 2'd0, 0);
    frame("R2 quad off", 1, 3, 0, 0);
    check("R2 quad frame no status", stat_code, 8'h00);
    send("R2 close", 0, 2'd2, 0);
    check("R2 frame survived quad noise", stat_code, 8'h18);
    ack("R9");
    quad_en = 1;
    frame("R3 quad on", 1, 5, 1, 0);
    check("R3 quad frame good", stat_code, 8'h04);
    ack("R9");

    // R9 priority: error over good, good does not override error
    irq_en = 1;
    frame("R9 bad", 0, 3, 1, 1);
    frame("R9 good after bad", 0, 3, 1, 0);
    check("R9 error held over good", stat_code, 8'h18);
    check("R7 irq with error", irq, 1'b1);
    @(negedge clk); irq_en = 0;
    @(negedge clk);
    check("R7 irq off when disabled", irq, 1'b0);
    ack("R9");

    // random mix
    for (int t = 0; t < 400; t++) begin
      loop_sel = 1'($urandom);
      quad_en  = 1'($urandom);
      irq_en   = 1'($urandom);
      frame("R4 R5 random", 1'($urandom_range(0, 3) == 0), $urandom_range(0, 12),
            $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) send("R11 random noise", 0, 2'd3, 0);
      if ($urandom_range(0, 1) == 0) ack("R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule